// File: doc/BRIEF.md
# SDRAM Write Burst Data Engine

This block is the device-side write path of a pipelined SDRAM bank array. Each clock it decodes the command pins (chip select, row strobe, column strobe, write enable) as the array registers them. On a WRITE it captures the starting bank, the starting column and the auto-precharge request. It then drives one write strobe per cycle, together with the bank and column that the storage array must update on the coming rising edge. The data mask input gates each strobe.

A burst runs for a fixed length of 1, 2, 4 or 8 words, or in full-page mode until another command stops it. Four commands can cut a burst short: a new WRITE, a READ, a BURST TERMINATE or a PRECHARGE. Each has its own rule about the word on its own cycle. A fixed-length burst that requested auto precharge and runs to its end raises a one-cycle close request for its bank. Burst length and page width are static configuration inputs.

Top module: `sdram_wr_engine`

## Requirements
- R1: A WRITE command (cs_n=0, ras_n=1, cas_n=0, we_n=0) with dqm low raises wr_en in that same cycle, with wr_bank equal to ba and wr_col equal to addr[9:0]. When narrow_page=1, bit 9 of the column is forced to 0.
- R2: A fixed-length burst presents one column per cycle after the WRITE. The column increments and wraps inside the aligned block of burst length. The lengths are coded on bl_sel as 0=1, 1=2, 2=4 and 3=8 words, and any other code except 7 acts as length 1.
- R3: dqm high in a burst cycle suppresses wr_en for that cycle only. The column still advances.
- R4: A fixed-length burst of length L produces exactly L beats, the WRITE cycle included. Later cycles with no new WRITE produce no wr_en.
- R5: With bl_sel=7 (full page) the burst continues until it is stopped. After column 1023 (511 when narrow_page=1) it wraps to column 0.
- R6: A WRITE accepted while a burst runs replaces that burst at once. The word on the new WRITE's cycle belongs to the new bank and column.
- R7: BURST TERMINATE (cs_n=0, ras_n=1, cas_n=1, we_n=0) produces no wr_en on its own cycle and ends the burst.
- R8: READ (cs_n=0, ras_n=1, cas_n=0, we_n=1) produces no wr_en on its own cycle and ends the burst.
- R9: PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0) ends the burst with no wr_en on its cycle when addr[10]=1 (all banks) or when ba equals the burst's bank. A PRECHARGE aimed at a different bank with addr[10]=0 leaves the burst running.
- R10: Deselect (cs_n=1), NOP (ras_n=cas_n=we_n=1) and ACTIVE (ras_n=0, cas_n=1, we_n=1) leave a burst in progress untouched.
- R11: addr[10] sampled with a WRITE selects auto precharge. A fixed-length burst that completes all its beats then pulses ap_close for one cycle, with ap_bank equal to its bank, in the cycle after its final beat. A burst that is truncated or in full-page mode never pulses ap_close.
- R12: While rst_n is low, wr_en stays low. On the first cycle after reset ap_close is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock; commands and data are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| addr | input | 12 | Address bus: start column in [9:0], auto-precharge / all-banks flag in [10] |
| ba | input | 2 | Bank select |
| dqm | input | 1 | Data mask; high blocks the word of this cycle |
| bl_sel | input | 3 | Static burst length code |
| narrow_page | input | 1 | Static; 1 selects the 512-column page |
| wr_en | output | 1 | Write strobe for the storage array, valid for the next rising edge |
| wr_bank | output | 2 | Bank to write |
| wr_col | output | 10 | Column to write |
| ap_close | output | 1 | One-cycle request to close the row of ap_bank |
| ap_bank | output | 2 | Bank whose row must be closed |

## Verification
The hardest states to reach are the column wrap of a full-page burst, which takes about a thousand uninterrupted cycles of a burst still running, and the wrap inside an aligned block of a fixed burst that starts near the top of its block. Random traffic stops bursts far too often to reach either. Directed sequences place a WRITE a few columns below the page end or at an odd offset in its block, then let the burst run on under deselects and ACTIVEs. The remaining stimulus is a weighted random mix of commands, masks and banks under every burst-length code and both page widths. A bench model predicts every cycle's strobe, column and close pulse.

// File: rtl/sdram_wr_pkg.sv
// Shared types for the SDRAM write burst engine.
// Assumes command pins are sampled on the rising clock edge, active low.
package sdram_wr_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,   // deselect or NOP
        CMD_WRITE,
        CMD_READ,
        CMD_STOP,   // burst terminate
        CMD_PRE,    // precharge
        CMD_OTHER   // any command that does not touch a write burst
    } cmd_e;

    localparam logic [2:0] BL_SEL_FULL = 3'b111;

    // Map the command pins to a command class.
    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_IDLE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b100:  c = CMD_WRITE;
                3'b101:  c = CMD_READ;
                3'b110:  c = CMD_STOP;
                3'b010:  c = CMD_PRE;
                3'b111:  c = CMD_IDLE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: classifies the pins and extracts the WRITE fields.
// Assumes the address bus is at least COL_W+1 bits wide and that the
// auto-precharge / all-banks flag sits at AP_BIT.
module sdram_cmd_decode
    import sdram_wr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow_page,
    output cmd_e              cmd,
    output logic [COL_W-1:0]  start_col,
    output logic              flag_a10
);

    // Classify the command and pull the column and flag off the bus.
    always_comb begin
        cmd       = decode_cmd(cs_n, ras_n, cas_n, we_n);
        start_col = addr[COL_W-1:0];
        if (narrow_page) begin
            start_col[COL_W-1] = 1'b0;
        end
        flag_a10  = addr[AP_BIT];
    end

endmodule

// File: rtl/sdram_col_next.sv
// Next-column generator. A fixed burst wraps inside its aligned block of
// 2**lg columns. A full-page burst counts up through the page and wraps to 0.
// Assumes a narrow page holds half the columns of a wide one.
module sdram_col_next #(
    parameter int COL_W = 10,
    parameter int LG_W  = 2
) (
    input  logic [COL_W-1:0] col,
    input  logic [LG_W-1:0]  lg,
    input  logic             full,
    input  logic             narrow_page,
    output logic [COL_W-1:0] nxt
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] inc;

    // Compute the column that follows col in the current burst order.
    always_comb begin
        mask = (COL_W'(1) << lg) - COL_W'(1);
        inc  = col + COL_W'(1);
        if (full) begin
            nxt = inc;
            if (narrow_page) begin
                nxt[COL_W-1] = 1'b0;
            end
        end else begin
            nxt = (col & ~mask) | (inc & mask);
        end
    end

endmodule

// File: rtl/sdram_burst_ctrl.sv
// Burst sequencer: holds the running burst and picks the beat of each cycle.
// The strobe is combinational so that the array captures the word on the
// edge that registers the command. Assumes lg and full are static while a
// burst runs.
module sdram_burst_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int COL_W       = 10,
    parameter int BANK_W      = 2,
    parameter int MAX_BL_LOG2 = 3,
    parameter int LG_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [COL_W-1:0]  start_col,
    input  logic [BANK_W-1:0] ba,
    input  logic              flag_a10,
    input  logic              dqm,
    input  logic [LG_W-1:0]   lg,
    input  logic              full,
    input  logic              narrow_page,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank
);

    localparam int REM_W = (MAX_BL_LOG2 < 1) ? 1 : MAX_BL_LOG2;

    logic              act_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [REM_W-1:0]  rem_q;
    logic              ap_q;

    logic              beat;
    logic              last;
    logic [BANK_W-1:0] beat_bank;
    logic [COL_W-1:0]  beat_col;
    logic [REM_W-1:0]  beat_rem;
    logic              beat_ap;
    logic [REM_W-1:0]  bl_m1;
    logic [COL_W-1:0]  col_nxt;

    sdram_col_next #(.COL_W(COL_W), .LG_W(LG_W)) u_next (
        .col         (beat_col),
        .lg          (lg),
        .full        (full),
        .narrow_page (narrow_page),
        .nxt         (col_nxt)
    );

    // Choose this cycle's beat: a new WRITE wins, a stop command ends it.
    always_comb begin
        bl_m1     = REM_W'((32'd1 << lg) - 32'd1);
        beat      = 1'b0;
        beat_bank = bank_q;
        beat_col  = col_q;
        beat_rem  = rem_q;
        beat_ap   = ap_q;
        if (cmd == CMD_WRITE) begin
            beat      = 1'b1;
            beat_bank = ba;
            beat_col  = start_col;
            beat_rem  = bl_m1;
            beat_ap   = flag_a10;
        end else if (act_q) begin
            unique case (cmd)
                CMD_READ, CMD_STOP: beat = 1'b0;
                CMD_PRE:            beat = !(flag_a10 || (ba == bank_q));
                default:            beat = 1'b1;
            endcase
        end
        last    = beat && !full && (beat_rem == '0);
        wr_en   = beat && !dqm && rst_n;
        wr_bank = beat_bank;
        wr_col  = beat_col;
    end

    // Register the burst state and the close request of a completed burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            bank_q   <= '0;
            col_q    <= '0;
            rem_q    <= '0;
            ap_q     <= 1'b0;
            ap_close <= 1'b0;
            ap_bank  <= '0;
        end else begin
            act_q    <= beat && !last;
            bank_q   <= beat_bank;
            col_q    <= col_nxt;
            rem_q    <= beat_rem - REM_W'(1);
            ap_q     <= beat_ap;
            ap_close <= last && beat_ap;
            ap_bank  <= beat_bank;
        end
    end

endmodule

// File: rtl/sdram_wr_engine.sv
// Top of the SDRAM write burst engine. Decodes the burst length code and
// ties the decoder to the sequencer. Assumes bl_sel and narrow_page change
// only while no burst runs.
module sdram_wr_engine
    import sdram_wr_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int COL_W       = 10,
    parameter int BANK_W      = 2,
    parameter int AP_BIT      = 10,
    parameter int MAX_BL_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] ba,
    input  logic              dqm,
    input  logic [2:0]        bl_sel,
    input  logic              narrow_page,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank
);

    localparam int LG_W = $clog2(MAX_BL_LOG2 + 1);

    cmd_e             cmd;
    logic [COL_W-1:0] start_col;
    logic             flag_a10;
    logic [LG_W-1:0]  lg;
    logic             full;

    // Turn the length code into a block size exponent or full-page mode.
    always_comb begin
        full = (bl_sel == BL_SEL_FULL);
        if (!full && (int'(bl_sel) <= MAX_BL_LOG2)) begin
            lg = LG_W'(bl_sel);
        end else begin
            lg = '0;
        end
    end

    sdram_cmd_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dec (
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .addr        (addr),
        .narrow_page (narrow_page),
        .cmd         (cmd),
        .start_col   (start_col),
        .flag_a10    (flag_a10)
    );

    sdram_burst_ctrl #(
        .COL_W(COL_W), .BANK_W(BANK_W), .MAX_BL_LOG2(MAX_BL_LOG2), .LG_W(LG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .start_col   (start_col),
        .ba          (ba),
        .flag_a10    (flag_a10),
        .dqm         (dqm),
        .lg          (lg),
        .full        (full),
        .narrow_page (narrow_page),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_col      (wr_col),
        .ap_close    (ap_close),
        .ap_bank     (ap_bank)
    );

endmodule

// File: rtl/sdram_wr_engine_chk.sv
// Protocol checker for sdram_wr_engine, attached by bind. It relates the
// command pins to the strobe outputs across cycles.
module sdram_wr_engine_chk #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 10,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] ba,
    input logic              dqm,
    input logic [2:0]        bl_sel,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_bank,
    input logic [COL_W-1:0]  wr_col,
    input logic              ap_close
);

    logic is_wr, is_rd, is_bst;

    // Recognise the commands the properties refer to.
    always_comb begin
        is_wr  = !cs_n && ras_n && !cas_n && !we_n;
        is_rd  = !cs_n && ras_n && !cas_n &&  we_n;
        is_bst = !cs_n && ras_n &&  cas_n && !we_n;
    end

    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !dqm);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !dqm) |-> (wr_en && wr_bank == ba && wr_col[COL_W-2:0] == addr[COL_W-2:0]));

    assert_bst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_bst |=> (is_wr || !wr_en));

    assert_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> !wr_en);

    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && bl_sel == 3'd0) |=> (is_wr || !wr_en));

    // R12: no strobe while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R12: assert (!wr_en);
        end
    end

    assert_reset_close_R12: assert property (@(posedge clk)
        !rst_n |=> !ap_close);

endmodule

bind sdram_wr_engine sdram_wr_engine_chk #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm), .bl_sel(bl_sel),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .ap_close(ap_close)
);

// File: tb/sim_sdram_wr_engine.sv
// Bench for sdram_wr_engine: directed corners plus seeded random traffic,
// checked each cycle against a model built from the requirements.
module sim_sdram_wr_engine;

    localparam int K_NOP = 0, K_WR = 1, K_RD = 2, K_BST = 3,
                   K_PRE = 4, K_DES = 5, K_ACT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [1:0]  ba = '0;
    logic        dqm = 1'b0;
    logic [2:0]  bl_sel = 3'd0;
    logic        narrow_page = 1'b0;
    logic        wr_en, ap_close;
    logic [1:0]  wr_bank, ap_bank;
    logic [9:0]  wr_col;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    bit m_act = 0, m_ap = 0, m_close = 0;
    int m_bank = 0, m_col = 0, m_rem = 0, m_cbank = 0;

    always #10 clk = ~clk;

    sdram_wr_engine u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm), .bl_sel(bl_sel),
        .narrow_page(narrow_page), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_col(wr_col), .ap_close(ap_close), .ap_bank(ap_bank)
    );

    function automatic int blen(input logic [2:0] s);
        case (s)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 0;   // full page
            default: return 1;
        endcase
    endfunction

    function automatic int next_col(input int c);
        int l, pg;
        l  = blen(bl_sel);
        pg = narrow_page ? 512 : 1024;
        if (l == 0) return (c + 1) % pg;
        return (c & ~(l - 1)) | ((c + 1) & (l - 1));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input int k, input logic [11:0] a, input logic [1:0] b, input logic d);
        cs_n = (k == K_DES);
        case (k)
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_BST:   {ras_n, cas_n, we_n} = 3'b110;
            K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        addr = a; ba = b; dqm = d;
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge,
    // then advance the model at the rising edge.
    task automatic step(input int k, input logic [11:0] a, input logic [1:0] b, input logic d);
        bit beat, last, e_ap;
        int e_bank, e_col, e_rem, l;
        string tag;
        drive(k, a, b, d);
        #9;
        l = blen(bl_sel);
        beat = 0; e_bank = m_bank; e_col = m_col; e_rem = m_rem; e_ap = m_ap;
        tag = m_act ? (l == 0 ? "R5" : "R2") : "R4";
        if (k == K_WR) begin
            beat = 1; e_bank = b; e_col = a[9:0];
            if (narrow_page) e_col = e_col & 511;
            e_rem = (l == 0) ? 0 : l - 1; e_ap = a[10];
            tag = m_act ? "R6" : "R1";
        end else if (m_act) begin
            if (k == K_RD) tag = "R8";
            else if (k == K_BST) tag = "R7";
            else if (k == K_PRE && (a[10] || b == 2'(m_bank))) tag = "R9";
            else begin
                beat = 1;
                if (k == K_PRE) tag = "R9";
                else if (k != K_NOP) tag = "R10";
            end
        end
        if (beat && d) tag = "R3";
        check(tag, int'(wr_en), int'(beat && !d));
        if (beat && !d) begin
            check(tag, int'(wr_bank), e_bank);
            check(tag, int'(wr_col), e_col);
        end
        check("R11", int'(ap_close), int'(m_close));
        if (m_close) check("R11", int'(ap_bank), m_cbank);
        last = beat && (l != 0) && (e_rem == 0);
        @(posedge clk);
        m_close = last && e_ap;
        m_cbank = e_bank;
        m_act   = beat && !last;
        m_bank  = e_bank;
        m_ap    = e_ap;
        m_rem   = e_rem - 1;
        m_col   = beat ? next_col(e_col) : m_col;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(K_WR, 12'h0_0_5, 2'd1, 1'b0);
        @(negedge clk);
        #9;
        check("R12", int'(wr_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(K_NOP, '0, '0, 1'b0);
        m_act = 0; m_close = 0;
        #9;
        check("R12", int'(ap_close), 0);
        check("R12", int'(wr_en), 0);
        @(negedge clk);
    endtask

    task automatic run_nops(input int n);
        for (int i = 0; i < n; i++) step((i % 3 == 0) ? K_DES : ((i % 3 == 1) ? K_ACT : K_NOP), 12'h0, 2'(i), 1'b0);
    endtask

    task automatic directed();
        int l, pg;
        l  = blen(bl_sel);
        pg = narrow_page ? 512 : 1024;
        // start near the top of the page / at an odd block offset
        step(K_WR, 12'(pg - 3), 2'd2, 1'b0);
        run_nops((l == 0) ? 6 : l + 2);                 // R5 wrap or R2/R4 end
        step(K_WR, 12'h405, 2'd3, 1'b0);                // auto precharge, R11
        run_nops((l == 0) ? 3 : l + 2);
        step(K_BST, 12'h0, 2'd0, 1'b0);
        step(K_WR, 12'h013, 2'd1, 1'b0);
        step(K_NOP, 12'h0, 2'd0, 1'b1);                 // masked beat R3
        step(K_BST, 12'h0, 2'd0, 1'b0);                 // R7
        step(K_NOP, 12'h0, 2'd0, 1'b0);
        step(K_WR, 12'h022, 2'd0, 1'b0);
        step(K_RD, 12'h0, 2'd0, 1'b0);                  // R8
        step(K_NOP, 12'h0, 2'd0, 1'b0);
        step(K_WR, 12'h031, 2'd1, 1'b0);
        step(K_PRE, 12'h000, 2'd2, 1'b0);               // other bank, R9
        step(K_PRE, 12'h000, 2'd1, 1'b0);               // own bank, R9
        step(K_WR, 12'h044, 2'd0, 1'b0);
        step(K_WR, 12'h457, 2'd3, 1'b0);                // back-to-back, R6
        step(K_PRE, 12'h400, 2'd0, 1'b0);               // all banks, R9
        step(K_NOP, 12'h0, 2'd0, 1'b0);
    endtask

    task automatic random_run(input int n);
        int r, k;
        for (int i = 0; i < n; i++) begin
            r = $urandom_range(99);
            if      (r < 40) k = K_NOP;
            else if (r < 58) k = K_WR;
            else if (r < 68) k = K_DES;
            else if (r < 73) k = K_RD;
            else if (r < 78) k = K_BST;
            else if (r < 88) k = K_PRE;
            else             k = K_ACT;
            step(k, 12'($urandom), 2'($urandom), ($urandom_range(3) == 0));
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        for (int np = 0; np < 2; np++) begin
            for (int s = 0; s < 6; s++) begin
                narrow_page = 1'(np);
                bl_sel = (s == 5) ? 3'd7 : ((s == 4) ? 3'd5 : 3'(s));
                do_reset();
                directed();
                random_run(1500);
            end
        end
        // long uninterrupted full-page run through a whole page, R5
        bl_sel = 3'd7; narrow_page = 1'b0;
        do_reset();
        step(K_WR, 12'h010, 2'd1, 1'b0);
        run_nops(1030);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule